// File: doc/BRIEF.md
# Mask-Driven Bit Gather Unit

This unit compacts an arbitrary set of source bits into the low end of a result word. The caller presents a data word and a selector word. The unit walks the selector from its least significant bit upward. For every set selector bit, it places the matching data bit in the next free result position, starting at result bit 0. Every result bit above the last one filled is cleared. The selected positions may be scattered anywhere in the word.

The operating width is 32 or 64 bits. The 64-bit width is used only when the long-mode indicator and the wide-operand bit are both high. In every other case the unit works on the low half of each input and clears the high half of the result. A request whose vector-length bit is set is an illegal encoding. It produces an undefined-operation flag and a zero result instead of a gathered word.

Requests enter through a valid/ready handshake. The result and the flag come from a single output register. They appear one clock after acceptance and stay there until the consumer takes them.

Top module: `bit_gather_unit`

## Requirements
- R1: Set selector bits are consumed in ascending position order. The data bit at the j-th set selector position (counting from 0) appears at result bit j.
- R2: All result bits at or above the number of active set selector bits are zero.
- R3: When `op_long_mode` is 0, the width is 32 bits whatever the value of `op_wide`. Input bits 63:32 of both operands have no effect, and result bits 63:32 are zero.
- R4: When `op_long_mode` is 1, `op_wide`=1 selects 64-bit operation and `op_wide`=0 selects 32-bit operation.
- R5: When `op_vlen` is 1, `res_undef` is 1 and `res_data` is zero. Otherwise `res_undef` is 0.
- R6: An all-zero selector gives a zero result. An all-ones selector returns the data operand unchanged within the active width.
- R7: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. `res_valid` is 1 in the next cycle. `req_ready` equals `!res_valid || res_ready`.
- R8: While `res_valid` is 1 and `res_ready` is 0, `res_data` and `res_undef` hold their values and `res_valid` stays 1.
- R9: After reset, `res_valid` is 0 and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can take a request |
| op_data | input | 64 | Source data word |
| op_sel | input | 64 | Selector word |
| op_wide | input | 1 | Wide-operand bit |
| op_long_mode | input | 1 | 64-bit mode indicator |
| op_vlen | input | 1 | Vector-length bit; 1 is illegal |
| res_valid | output | 1 | Result present |
| res_ready | input | 1 | Consumer takes the result |
| res_data | output | 64 | Gathered result |
| res_undef | output | 1 | Undefined-operation flag |

## Verification
The output register is the only state in this unit, so a wrong internal value shows up in `res_data` or `res_undef` in the cycle right after acceptance. A fault in the gather chain, such as a skipped selector bit, an off-by-one output index, or a missing width gate, misplaces or leaks data bits at a position the reference can predict. A broken hold path shows up as a value that changes during a consumer stall. A wrong ready equation shows up as a request that is accepted, or refused, in the wrong cycle. The random mix of selector densities, widths and stall lengths exposes each of these within a few transactions.

// File: rtl/bit_gather_unit.sv
module bit_gather_unit #(
  parameter int DW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [DW-1:0] op_data,
  input  logic [DW-1:0] op_sel,
  input  logic          op_wide,
  input  logic          op_long_mode,
  input  logic          op_vlen,
  output logic          res_valid,
  input  logic          res_ready,
  output logic [DW-1:0] res_data,
  output logic          res_undef
);
  localparam int HW = DW / 2;
  localparam int IW = $clog2(DW) + 1;

  logic          full_width;
  logic [DW-1:0] eff_sel;
  logic [DW-1:0] packed_bits;
  logic          accept;

  assign full_width = op_long_mode & op_wide;
  assign eff_sel    = full_width ? op_sel : {{HW{1'b0}}, op_sel[HW-1:0]};
  assign req_ready  = !res_valid || res_ready;
  assign accept     = req_valid && req_ready;

  always_comb begin
    logic [IW-1:0] k;
    packed_bits = '0;
    k = '0;
    for (int i = 0; i < DW; i++) begin
      if (eff_sel[i]) begin
        packed_bits[k[IW-2:0]] = op_data[i];
        k = k + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_data  <= '0;
      res_undef <= 1'b0;
    end else if (accept) begin
      res_valid <= 1'b1;
      res_undef <= op_vlen;
      res_data  <= op_vlen ? '0 : packed_bits;
    end else if (res_ready) begin
      res_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/bit_gather_unit_chk.sv
module bit_gather_unit_chk #(
  parameter int DW = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          op_wide,
  input logic          op_long_mode,
  input logic          res_valid,
  input logic          res_ready,
  input logic [DW-1:0] res_data,
  input logic          res_undef
);
  localparam int HW = DW / 2;
  logic narrow_q;

  always_ff @(posedge clk) begin
    if (!rst_n) narrow_q <= 1'b0;
    else if (req_valid && req_ready) narrow_q <= !(op_long_mode && op_wide);
  end

  a_r5_undef_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_undef) |-> (res_data == '0));

  a_r7_valid_next: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> res_valid);

  a_r7_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> req_ready);

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_data) && $stable(res_undef)));

  a_r3_upper_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && narrow_q) |-> (res_data[DW-1:HW] == '0));

  a_r9_reset_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !res_valid);
endmodule

bind bit_gather_unit bit_gather_unit_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .op_wide(op_wide), .op_long_mode(op_long_mode), .res_valid(res_valid),
  .res_ready(res_ready), .res_data(res_data), .res_undef(res_undef)
);

// File: tb/bit_gather_unit_tb.sv
module bit_gather_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [63:0] op_data = '0;
  logic [63:0] op_sel = '0;
  logic        op_wide = 1'b0;
  logic        op_long_mode = 1'b0;
  logic        op_vlen = 1'b0;
  logic        res_valid;
  logic        res_ready = 1'b1;
  logic [63:0] res_data;
  logic        res_undef;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  bit_gather_unit u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .op_data(op_data), .op_sel(op_sel), .op_wide(op_wide),
    .op_long_mode(op_long_mode), .op_vlen(op_vlen), .res_valid(res_valid),
    .res_ready(res_ready), .res_data(res_data), .res_undef(res_undef)
  );

  function automatic logic [63:0] ref_gather(logic [63:0] d, logic [63:0] m,
                                             logic w, logic lm, logic l);
    logic [63:0] r = '0;
    int n = 0;
    int top = (lm && w) ? 64 : 32;
    if (l) return '0;
    for (int i = 0; i < top; i++)
      if (m[i]) begin
        r = r | (64'(d[i]) << n);
        n++;
      end
    return r;
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run(string req, logic [63:0] d, logic [63:0] m, logic w,
                     logic lm, logic l, int stall);
    logic [63:0] exp = ref_gather(d, m, w, lm, l);
    @(negedge clk);
    check("R7 ready before request", 64'(req_ready), 64'd1);
    op_data = d; op_sel = m; op_wide = w; op_long_mode = lm; op_vlen = l;
    req_valid = 1'b1;
    res_ready = (stall == 0);
    @(negedge clk);
    req_valid = 1'b0;
    op_data = $urandom(); op_sel = $urandom();
    check("R7 valid after accept", 64'(res_valid), 64'd1);
    check(req, res_data, exp);
    check("R5 undef flag", 64'(res_undef), 64'(l));
    for (int s = 0; s < stall; s++) begin
      @(negedge clk);
      check("R8 held valid", 64'(res_valid), 64'd1);
      check("R8 held data", res_data, exp);
      check("R7 ready low in stall", 64'(req_ready), 64'd0);
    end
    res_ready = 1'b1;
    @(negedge clk);
    check("R7 valid drops after take", 64'(res_valid), 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R9 reset valid", 64'(res_valid), 64'd0);
    check("R9 reset ready", 64'(req_ready), 64'd1);
    rst_n = 1'b1;

    run("R1 example", 64'h0000_0000_1000_00A4, 64'h0000_0000_1000_00A4, 0, 0, 0, 0);
    run("R1 scatter", 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_1000_00A4, 0, 0, 0, 1);
    run("R2 upper zero", 64'hDEAD_BEEF_CAFE_F00D, 64'h8000_0000_0000_0001, 1, 1, 0, 0);
    run("R3 narrow ignores W", 64'hFFFF_FFFF_1234_5678, 64'hFFFF_FFFF_FFFF_FFFF, 1, 0, 0, 0);
    run("R4 long narrow", 64'hABCD_0000_0F0F_0F0F, 64'hFFFF_0000_FFFF_FFFF, 0, 1, 0, 2);
    run("R4 long wide", 64'hABCD_0000_0F0F_0F0F, 64'hFFFF_0000_FFFF_FFFF, 1, 1, 0, 0);
    run("R5 illegal length", 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 1, 1, 1, 3);
    run("R6 zero selector", 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 1, 1, 0, 0);
    run("R6 ones selector wide", 64'h0123_4567_89AB_CDEF, 64'hFFFF_FFFF_FFFF_FFFF, 1, 1, 0, 0);
    run("R6 ones selector narrow", 64'h0123_4567_89AB_CDEF, 64'hFFFF_FFFF_FFFF_FFFF, 0, 1, 0, 0);

    void'($urandom(32'h5eed));
    for (int t = 0; t < 400; t++) begin
      logic [63:0] d = {$urandom(), $urandom()};
      logic [63:0] m = {$urandom(), $urandom()};
      case (t % 3)
        0: m = m & {$urandom(), $urandom()};
        1: m = m | {$urandom(), $urandom()};
        default: ;
      endcase
      run("R1 R2 random", d, m, 1'($urandom()), 1'($urandom()),
          1'(($urandom() % 8) == 0), $urandom() % 3);
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule